// File: doc/BRIEF.md
# GPIO Pin Interrupt Controller

This block turns the 32 input pins of one general-purpose I/O port into a single interrupt request. Each pin is brought into the clock domain by a two-stage synchronizer. Four per-pin configuration words set how each pin is handled:
- a routing bit, which admits the pin to detection;
- an enable bit, which lets a pending pin drive the interrupt line;
- a mode bit, which picks level or edge detection;
- a sense bit, which picks the active level or the active edge.

A detected condition latches a per-pin pending bit. The interrupt output is high while any pending bit has its enable bit set.

Software reaches the configuration words and the pending word through a simple register bus. The bus has an 8-bit address, a 32-bit write word, a write strobe and a combinational read word. Every word can be written three ways: a direct write, an OR-in write and an AND-NOT write.

Pending bits clear only through the AND-NOT alias. A pending bit for a level-mode pin cannot be cleared while its pin is still active and still routed. Software must either remove the condition at the pin, or take the pin out of detection by clearing its routing bit. Only then does the pending bit clear.

Top module: `gpirq_ctrl`

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: Word offsets are: routing 0x00, enable 0x10, mode 0x20, sense 0x30, pending 0x40. Writing at word+0 loads the write word, word+4 sets the masked bits, and word+8 clears the masked bits. A read at any of the three aliases returns the word's current value.
- R3: Writes to the pending word at +0 or +4 leave it unchanged. A pending bit falls only by a write of a 1 to that bit at pending+8.
- R4: Edge mode is mode bit 0. With sense bit 1 a rising edge sets the pending bit; with sense bit 0 a falling edge sets it. The bit stays set after the pin returns, and it shows on the third rising clock edge after the pin changes.
- R5: Level mode is mode bit 1. With sense bit 1 a high pin is active; with sense bit 0 a low pin is active. The pending bit is set on every cycle in which the pin is active.
- R6: In level mode, a clear of a pending bit has no effect while the pin is active and its routing bit is 1. With the routing bit at 0, the same clear removes the bit.
- R7: A pin whose routing bit is 0 never sets its pending bit.
- R8: `irq` is the OR over all pins of the pending bit AND the enable bit. A pending pin with enable 0 does not raise `irq`.
- R9: When a set condition and a clear write hit the same pending bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 32 | Asynchronous pin inputs |
| addr | input | 8 | Register byte address |
| wdata | input | 32 | Write word |
| wr | input | 1 | Write strobe, one write per cycle while high |
| rdata | output | 32 | Read word for `addr` |
| irq | output | 1 | Combined interrupt request |

## Verification
A table of bus writes first walks each alias on several configuration words. It reads every result back, which separates direct, OR-in and AND-NOT writes and confirms that pending-word writes are ignored.

Directed pin patterns then cover the following:
- a rising pulse, which separates edge from level capture;
- a falling pulse under opposite sense, which shows polarity selects the edge;
- a held-high level pin, cleared both while routed and after routing is withdrawn;
- a pin that is low at the moment it is routed;
- an edge timed to coincide with a clear write.

Enable bits are toggled while bits are pending to show that only the output gating changes.

// File: rtl/gpirq_pkg.sv
package gpirq_pkg;

    localparam int GP_PINS = 32;
    localparam int ADDR_W  = 8;

    // word index follows address bits [6:4]
    typedef enum logic [2:0] {
        RG_SRC  = 3'd0,
        RG_EN   = 3'd1,
        RG_LVL  = 3'd2,
        RG_POL  = 3'd3,
        RG_STAT = 3'd4,
        RG_NONE = 3'd7
    } reg_e;

    // alias follows address bits [3:2]
    typedef enum logic [1:0] {
        AL_PLAIN = 2'd0,
        AL_SET   = 2'd1,
        AL_CLR   = 2'd2,
        AL_BAD   = 2'd3
    } alias_e;

    typedef struct packed {
        reg_e   rsel;
        alias_e als;
    } dec_t;

    function automatic dec_t decode(input logic [ADDR_W-1:0] a);
        dec_t d;
        d.als  = alias_e'(a[3:2]);
        d.rsel = RG_NONE;
        if (a[1:0] == 2'b00 && a[3:2] != 2'b11 && a[7:4] <= 4'd4)
            d.rsel = reg_e'(a[6:4]);
        return d;
    endfunction

endpackage

// File: rtl/gpirq_sync.sv
module gpirq_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/gpirq_detect.sv
module gpirq_detect #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_s,
    input  logic [W-1:0] src,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] pol,
    output logic [W-1:0] act,
    output logic [W-1:0] setc
);
    logic [W-1:0] prev;
    logic [W-1:0] edge_hit;

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= pin_s;
    end

    always_comb begin
        // sense 1: high level / rising edge, sense 0: low level / falling edge
        act      = (pin_s & pol) | (~pin_s & ~pol);
        edge_hit = (pin_s & ~prev & pol) | (~pin_s & prev & ~pol);
        setc     = src & ((lvl & act) | (~lvl & edge_hit));
    end

    // an unrouted pin never produces a set condition
    assert_setc_routed_R7: assert property (@(posedge clk) disable iff (rst)
        (setc & ~src) == '0);
endmodule

// File: rtl/gpirq_cfgreg.sv
module gpirq_cfgreg
    import gpirq_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hit,
    input  alias_e       als,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (hit) begin
            unique case (als)
                AL_PLAIN: q <= wdata;
                AL_SET:   q <= q | wdata;
                AL_CLR:   q <= q & ~wdata;
                default:  q <= q;
            endcase
        end
    end
endmodule

// File: rtl/gpirq_status.sv
module gpirq_status #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] src,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] act,
    input  logic [W-1:0] setc,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] stat_q
);
    logic [W-1:0] hold;
    logic [W-1:0] clr_eff;

    always_comb begin
        // level pins still asserting and routed refuse the clear
        hold    = lvl & act & src;
        clr_eff = clr_mask & ~hold;
    end

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= (stat_q & ~clr_eff) | setc;
    end

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat_q & $past(setc)) == $past(setc)));

    assert_fall_only_by_clear_R3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((~stat_q & $past(stat_q) & ~$past(clr_mask)) == '0));

    assert_level_hold_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat_q & $past(hold & stat_q)) == $past(hold & stat_q)));

    assert_no_unrouted_rise_R7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(src)) == '0));
endmodule

// File: rtl/gpirq_ctrl.sv
module gpirq_ctrl
    import gpirq_pkg::*;
#(
    parameter int PINS = GP_PINS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PINS-1:0]   pin_i,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PINS-1:0]   wdata,
    input  logic              wr,
    output logic [PINS-1:0]   rdata,
    output logic              irq
);
    localparam int NCFG = 4;

    dec_t            dec;
    logic [PINS-1:0] cfg [NCFG];
    logic [PINS-1:0] pin_s;
    logic [PINS-1:0] act;
    logic [PINS-1:0] setc;
    logic [PINS-1:0] clr_mask;
    logic [PINS-1:0] stat_q;

    assign dec = decode(addr);

    for (genvar g = 0; g < NCFG; g++) begin : g_cfg
        gpirq_cfgreg #(.W(PINS)) u_reg (
            .clk   (clk),
            .rst   (rst),
            .hit   (wr && dec.rsel == reg_e'(g)),
            .als   (dec.als),
            .wdata (wdata),
            .q     (cfg[g])
        );
    end

    gpirq_sync #(.W(PINS)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_i),
        .q   (pin_s)
    );

    gpirq_detect #(.W(PINS)) u_detect (
        .clk   (clk),
        .rst   (rst),
        .pin_s (pin_s),
        .src   (cfg[RG_SRC]),
        .lvl   (cfg[RG_LVL]),
        .pol   (cfg[RG_POL]),
        .act   (act),
        .setc  (setc)
    );

    assign clr_mask = (wr && dec.rsel == RG_STAT && dec.als == AL_CLR) ? wdata : '0;

    gpirq_status #(.W(PINS)) u_status (
        .clk      (clk),
        .rst      (rst),
        .src      (cfg[RG_SRC]),
        .lvl      (cfg[RG_LVL]),
        .act      (act),
        .setc     (setc),
        .clr_mask (clr_mask),
        .stat_q   (stat_q)
    );

    always_comb begin
        unique case (dec.rsel)
            RG_SRC:  rdata = cfg[RG_SRC];
            RG_EN:   rdata = cfg[RG_EN];
            RG_LVL:  rdata = cfg[RG_LVL];
            RG_POL:  rdata = cfg[RG_POL];
            RG_STAT: rdata = stat_q;
            default: rdata = '0;
        endcase
    end

    assign irq = |(stat_q & cfg[RG_EN]);

    assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (rst)
        irq |-> (|cfg[RG_EN]));

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> !irq);
endmodule

// File: tb/gpirq_ctrl_bench.sv
module gpirq_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 10;

    // {address, write word, expected read-back at that address}
    localparam logic [71:0] VECS [NV] = '{
        {8'h00, 32'hA5A5_0000, 32'hA5A5_0000},
        {8'h04, 32'h0000_00FF, 32'hA5A5_00FF},
        {8'h08, 32'hA000_000F, 32'h05A5_00F0},
        {8'h10, 32'h1234_5678, 32'h1234_5678},
        {8'h18, 32'h0000_0078, 32'h1234_5600},
        {8'h24, 32'h8000_0001, 32'h8000_0001},
        {8'h34, 32'h0000_0003, 32'h0000_0003},
        {8'h38, 32'h0000_0001, 32'h0000_0002},
        {8'h40, 32'hFFFF_FFFF, 32'h0000_0000},
        {8'h44, 32'hFFFF_FFFF, 32'h0000_0000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pins = '0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        wr = 1'b0;
    logic [31:0] rdata;
    logic        irq;
    int          nchk = 0;
    int          nerr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpirq_ctrl u_gpirq_ctrl (
        .clk (clk), .rst (rst), .pin_i (pins), .addr (addr),
        .wdata (wdata), .wr (wr), .rdata (rdata), .irq (irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        check(tag, rdata, exp);
    endtask

    task automatic wait3();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset values
        for (int i = 0; i < 5; i++) rd_chk("R1 reset word", 8'(i * 16), 32'h0);
        check("R1 irq after reset", {31'h0, irq}, 32'h0);

        // R2 / R3: alias table
        for (int i = 0; i < NV; i++) begin
            wr_reg(VECS[i][71:64], VECS[i][63:32]);
            rd_chk((VECS[i][71:64] >= 8'h40) ? "R3 pending write ignored" : "R2 alias write",
                   VECS[i][71:64], VECS[i][31:0]);
        end
        rd_chk("R2 read via clear alias", 8'h28, 32'h8000_0001);

        wr_reg(8'h08, '1); wr_reg(8'h18, '1); wr_reg(8'h28, '1);
        wr_reg(8'h38, '1); wr_reg(8'h48, '1);

        // R4: rising edge on pin 3
        wr_reg(8'h04, 32'h8); wr_reg(8'h14, 32'h8); wr_reg(8'h34, 32'h8);
        @(negedge clk); pins[3] = 1'b1;
        repeat (2) @(negedge clk);
        rd_chk("R4 not yet after two edges", 8'h40, 32'h0);
        @(negedge clk);
        rd_chk("R4 rising edge captured", 8'h40, 32'h8);
        check("R8 irq with enable", {31'h0, irq}, 32'h1);
        pins[3] = 1'b0; wait3();
        rd_chk("R4 sticky after return", 8'h40, 32'h8);
        wr_reg(8'h40, 32'h0); wr_reg(8'h44, 32'h10);
        rd_chk("R3 plain and set ignored", 8'h40, 32'h8);
        wr_reg(8'h48, 32'h8);
        rd_chk("R4 edge bit cleared", 8'h40, 32'h0);
        check("R8 irq drops", {31'h0, irq}, 32'h0);

        // R4: falling edge on pin 4, sense 0
        wr_reg(8'h04, 32'h10);
        pins[4] = 1'b1; wait3();
        rd_chk("R4 rising ignored under falling sense", 8'h40, 32'h0);
        pins[4] = 1'b0; wait3();
        rd_chk("R4 falling edge captured", 8'h40, 32'h10);
        check("R8 disabled pin gated", {31'h0, irq}, 32'h0);
        wr_reg(8'h14, 32'h10);
        check("R8 enable raises irq", {31'h0, irq}, 32'h1);
        wr_reg(8'h48, 32'h10); wr_reg(8'h18, 32'h18);

        // R5 / R6: level high on pin 5
        wr_reg(8'h24, 32'h20); wr_reg(8'h34, 32'h20); wr_reg(8'h04, 32'h20);
        pins[5] = 1'b1; wait3();
        rd_chk("R5 level high captured", 8'h40, 32'h20);
        wr_reg(8'h48, 32'h20);
        rd_chk("R6 clear refused while active", 8'h40, 32'h20);
        wr_reg(8'h08, 32'h20);
        wr_reg(8'h48, 32'h20);
        rd_chk("R6 clear after unrouting", 8'h40, 32'h0);
        wait3();
        rd_chk("R7 unrouted active pin stays clear", 8'h40, 32'h0);
        pins[5] = 1'b0;
        wr_reg(8'h04, 32'h20); wait3();
        rd_chk("R5 inactive level sets nothing", 8'h40, 32'h0);

        // R9: edge set and clear in the same cycle on pin 3
        @(negedge clk); pins[3] = 1'b1;
        repeat (2) @(negedge clk);
        addr = 8'h48; wdata = 32'h8; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
        rd_chk("R9 set wins over clear", 8'h40, 32'h8);
        wr_reg(8'h48, 32'h8);
        rd_chk("R9 later clear works", 8'h40, 32'h0);

        // R5: level low on pin 6, active as soon as routed
        wr_reg(8'h24, 32'h40); wr_reg(8'h04, 32'h40); wait3();
        rd_chk("R5 level low captured", 8'h40, 32'h40);
        pins[6] = 1'b1; wait3();
        wr_reg(8'h48, 32'h40);
        rd_chk("R6 clear after pin inactive", 8'h40, 32'h0);

        // R7: unrouted pin edge
        pins[9] = 1'b1; wait3(); pins[9] = 1'b0; wait3();
        rd_chk("R7 unrouted edge ignored", 8'h40, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end
endmodule